// File: doc/BRIEF.md
# Threshold Histogram Compression Unit

This block reduces the range of a stream of pixel values and gathers statistics on them as they pass. A set of ascending thresholds, which may be rewritten at any time, divides the value range. Each accepted pixel is placed in a histogram bin and also turned into one output value. The mode input picks the output: the pixel limited to the outer thresholds, the pixel raised to the first threshold that is not below it, or a binary edge decision with hysteresis between a low and a high threshold.

The unit takes one pixel per clock. It marks the first pixel of a frame, the first pixel of a line and the last pixel of a frame with flag inputs. On every frame it keeps saturating bin counters and the largest pixel value seen. At the last pixel of the frame it copies both into status outputs, which then hold steady while the next frame is gathered.

Top module: `thresh_hist_unit`

## Requirements
- R1: Each accepted pixel (`in_valid` high) gives exactly one result: `out_valid` is high on the next clock with that pixel's output value. A cycle with `in_valid` low gives `out_valid` low on the next clock.
- R2: Threshold k sits at bits k*DW upward of `thresholds`, for k = 0 to NTH-1. In clip mode (`mode` 0, and also the unused code 3), the output is threshold 0 when the pixel is below it. It is threshold NTH-1 when the pixel is above that threshold. Otherwise it is the pixel itself.
- R3: In quantize mode (`mode` 1), the output is the lowest threshold whose value is at or above the pixel. A pixel above every threshold gives threshold NTH-1.
- R4: In hysteresis mode (`mode` 2), the output is 0 or 1 in bit 0. It becomes 1 when a pixel is at or above threshold NTH-1. It becomes 0 when a pixel is below threshold 0. Otherwise it keeps its last value. A pixel flagged `in_sol` starts from state 0 before that pixel is judged.
- R5: Bin 0 counts pixels below threshold 1. Bin j (0 < j < NTH-2) counts pixels at or above threshold j and below threshold j+1. Bin NTH-2 counts pixels at or above threshold NTH-2. Bin j is reported at bits j*CW upward of `stat_hist`.
- R6: A pixel flagged `in_sof` clears all bin counters and the running maximum before it is counted itself. A frame of a single pixel (`in_sof` and `in_eof` together) therefore reports only that pixel.
- R7: A bin counter stops at its all-ones value and does not wrap.
- R8: `stat_max` reports the largest pixel value of the frame, the last pixel included.
- R9: `stat_max` and `stat_hist` change only on the clock that accepts a pixel flagged `in_eof`. They are visible from the next cycle and hold at all other times.
- R10: After reset, `out_valid`, `out_pix`, `stat_max` and every bin of `stat_hist` are zero.
- R11: A new threshold or mode value applies to the very next accepted pixel, with no frame-boundary delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 2 | 0 clip, 1 quantize, 2 hysteresis, 3 clip |
| thresholds | input | NTH*DW | Ascending thresholds, threshold k at bits k*DW |
| in_valid | input | 1 | Pixel accepted this cycle |
| in_pix | input | DW | Pixel value |
| in_sol | input | 1 | Pixel is first of a line |
| in_sof | input | 1 | Pixel is first of a frame |
| in_eof | input | 1 | Pixel is last of a frame |
| out_valid | output | 1 | Result present |
| out_pix | output | DW | Clipped, quantized or hysteresis result |
| stat_max | output | DW | Maximum pixel of the last completed frame |
| stat_hist | output | (NTH-1)*CW | Bin counts of the last completed frame, bin j at bits j*CW |

## Verification
Two functions can meet on one accepted pixel: the start-of-frame clear and the end-of-frame status capture. Both fall on a one-pixel frame. The bench sends such a frame after a long saturated one and expects the status to show just that pixel's value and a count of one in its bin. A second meeting is a line start that lands on a value between the hysteresis bounds while the state is 1. The bench sends this directly and expects 0, not the value held from before. All other outputs are judged against an arithmetic model over full up-and-down sweeps of every pixel value, for several threshold sets, including sets with equal thresholds.

// File: rtl/thu_pkg.sv
package thu_pkg;
    typedef enum logic [1:0] {
        MODE_CLIP  = 2'd0,
        MODE_QUANT = 2'd1,
        MODE_HYST  = 2'd2,
        MODE_CLIPX = 2'd3
    } mode_e;
endpackage

// File: rtl/thu_classify.sv
module thu_classify #(
    parameter int DW  = 8,
    parameter int NTH = 5,
    parameter int BW  = 2
) (
    input  logic [DW-1:0]     pix,
    input  logic [NTH*DW-1:0] th_flat,
    output logic [BW-1:0]     bin,
    output logic [DW-1:0]     quant_val,
    output logic [DW-1:0]     clip_val,
    output logic              at_high,
    output logic              below_low
);
    logic [DW-1:0] th [NTH];
    logic [NTH-1:0] ge;

    for (genvar i = 0; i < NTH; i++) begin : g_th
        assign th[i] = th_flat[i*DW +: DW];
        assign ge[i] = (pix >= th[i]);
    end

    // bin index: inner thresholds 1..NTH-2 reached by the pixel
    always_comb begin
        bin = '0;
        for (int i = 1; i < NTH-1; i++) begin
            if (ge[i]) bin = bin + BW'(1);
        end
    end

    // lowest threshold at or above the pixel, top threshold otherwise
    always_comb begin
        quant_val = th[NTH-1];
        for (int i = NTH-1; i >= 0; i--) begin
            if (th[i] >= pix) quant_val = th[i];
        end
    end

    always_comb begin
        if (!ge[0])                clip_val = th[0];
        else if (pix > th[NTH-1])  clip_val = th[NTH-1];
        else                       clip_val = pix;
    end

    assign at_high   = ge[NTH-1];
    assign below_low = !ge[0];
endmodule

// File: rtl/thu_mode.sv
module thu_mode
    import thu_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_sol,
    input  logic [1:0]    mode,
    input  logic [DW-1:0] clip_val,
    input  logic [DW-1:0] quant_val,
    input  logic          at_high,
    input  logic          below_low,
    input  logic [DW-1:0] th_lo,
    input  logic [DW-1:0] th_hi,
    output logic          out_valid,
    output logic [DW-1:0] out_pix
);
    typedef struct packed {
        logic          vld;
        logic [DW-1:0] pix;
        logic          hyst;
        logic [1:0]    mode;
    } mode_st_t;

    mode_st_t st_d, st_q;
    logic     hyst_c;

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        hyst_c   = in_sol ? 1'b0 : st_q.hyst;
        if (at_high)        hyst_c = 1'b1;
        else if (below_low) hyst_c = 1'b0;
        if (in_valid) begin
            st_d.hyst = hyst_c;
            st_d.mode = mode;
            case (mode_e'(mode))
                MODE_QUANT: st_d.pix = quant_val;
                MODE_HYST:  st_d.pix = DW'(hyst_c);
                default:    st_d.pix = clip_val;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_pix   = st_q.pix;

    // R1: one result per accepted pixel, one cycle later
    a_r1_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R2: clip output stays inside the outer thresholds
    a_r2_clip_range: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 2'd0 && th_lo <= th_hi)
        |=> (out_pix >= $past(th_lo) && out_pix <= $past(th_hi)));
    // R4: hysteresis result is binary
    a_r4_binary: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && st_q.mode == 2'd2) |-> (out_pix <= DW'(1)));
    // R4: line start below the high bound gives 0
    a_r4_line_start: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sol && mode == 2'd2 && !at_high) |=> (out_pix == '0));
endmodule

// File: rtl/thu_hist.sv
module thu_hist #(
    parameter int DW   = 8,
    parameter int NBIN = 4,
    parameter int BW   = 2,
    parameter int CW   = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic                      in_sof,
    input  logic                      in_eof,
    input  logic [DW-1:0]             pix,
    input  logic [BW-1:0]             bin,
    output logic [DW-1:0]             stat_max,
    output logic [NBIN-1:0][CW-1:0]   stat_hist
);
    localparam logic [CW-1:0] CNT_TOP = '1;

    typedef struct packed {
        logic [NBIN-1:0][CW-1:0] cnt;
        logic [DW-1:0]           run_max;
        logic [NBIN-1:0][CW-1:0] shist;
        logic [DW-1:0]           smax;
    } hist_st_t;

    hist_st_t      st_d, st_q;
    logic [CW-1:0] base;
    logic [DW-1:0] mx;

    always_comb begin
        st_d = st_q;
        base = '0;
        mx   = in_sof ? pix : ((pix > st_q.run_max) ? pix : st_q.run_max);
        if (in_valid) begin
            for (int b = 0; b < NBIN; b++) begin
                base = in_sof ? '0 : st_q.cnt[b];
                if (bin == BW'(b) && base != CNT_TOP) base = base + CW'(1);
                st_d.cnt[b] = base;
            end
            st_d.run_max = mx;
            if (in_eof) begin
                st_d.shist = st_d.cnt;
                st_d.smax  = mx;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_max  = st_q.smax;
    assign stat_hist = st_q.shist;

    for (genvar b = 0; b < NBIN; b++) begin : g_chk
        // R7: within a frame a counter never goes down (no wrap)
        a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && !in_sof) |=> (st_q.cnt[b] >= $past(st_q.cnt[b])));
    end
    // R9: status holds except after an end-of-frame pixel
    a_r9_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_eof) |=> ($stable(stat_max) && $stable(stat_hist)));
    // R8: captured maximum covers the last pixel
    a_r8_max_last: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_eof) |=> (stat_max >= $past(pix)));
    // R6: a start-of-frame pixel leaves exactly one count in the frame
    a_r6_sof_seed: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sof) |=> ($countones(st_q.cnt) == 1 && st_q.cnt[$past(bin)] == CW'(1)));
endmodule

// File: rtl/thresh_hist_unit.sv
module thresh_hist_unit #(
    parameter int DW  = 8,
    parameter int NTH = 5,
    parameter int CW  = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [1:0]              mode,
    input  logic [NTH*DW-1:0]       thresholds,
    input  logic                    in_valid,
    input  logic [DW-1:0]           in_pix,
    input  logic                    in_sol,
    input  logic                    in_sof,
    input  logic                    in_eof,
    output logic                    out_valid,
    output logic [DW-1:0]           out_pix,
    output logic [DW-1:0]           stat_max,
    output logic [(NTH-1)*CW-1:0]   stat_hist
);
    localparam int NBIN = NTH - 1;
    localparam int BW   = (NBIN > 1) ? $clog2(NBIN) : 1;

    logic [BW-1:0]           bin;
    logic [DW-1:0]           quant_val;
    logic [DW-1:0]           clip_val;
    logic                    at_high;
    logic                    below_low;
    logic [NBIN-1:0][CW-1:0] hist_w;

    thu_classify #(.DW(DW), .NTH(NTH), .BW(BW)) u_classify (
        .pix       (in_pix),
        .th_flat   (thresholds),
        .bin       (bin),
        .quant_val (quant_val),
        .clip_val  (clip_val),
        .at_high   (at_high),
        .below_low (below_low)
    );

    thu_mode #(.DW(DW)) u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sol    (in_sol),
        .mode      (mode),
        .clip_val  (clip_val),
        .quant_val (quant_val),
        .at_high   (at_high),
        .below_low (below_low),
        .th_lo     (thresholds[DW-1:0]),
        .th_hi     (thresholds[NTH*DW-1 -: DW]),
        .out_valid (out_valid),
        .out_pix   (out_pix)
    );

    thu_hist #(.DW(DW), .NBIN(NBIN), .BW(BW), .CW(CW)) u_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sof    (in_sof),
        .in_eof    (in_eof),
        .pix       (in_pix),
        .bin       (bin),
        .stat_max  (stat_max),
        .stat_hist (hist_w)
    );

    assign stat_hist = hist_w;
endmodule

// File: tb/thresh_hist_unit_bench.sv
module thresh_hist_unit_bench;
    localparam int TDW  = 6;
    localparam int TNTH = 5;
    localparam int TCW  = 5;
    localparam int TNB  = TNTH - 1;
    localparam int SAT  = (1 << TCW) - 1;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic [1:0]             mode = '0;
    logic [TNTH*TDW-1:0]    thresholds = '0;
    logic                   in_valid = 1'b0;
    logic [TDW-1:0]         in_pix = '0;
    logic                   in_sol = 1'b0;
    logic                   in_sof = 1'b0;
    logic                   in_eof = 1'b0;
    logic                   out_valid;
    logic [TDW-1:0]         out_pix;
    logic [TDW-1:0]         stat_max;
    logic [TNB*TCW-1:0]     stat_hist;

    always #2.5 clk = ~clk;

    thresh_hist_unit #(.DW(TDW), .NTH(TNTH), .CW(TCW)) u_thresh_hist_unit (
        .clk, .rst_n, .mode, .thresholds, .in_valid, .in_pix, .in_sol,
        .in_sof, .in_eof, .out_valid, .out_pix, .stat_max, .stat_hist
    );

    int errors = 0;
    int checks = 0;
    bit done = 0;
    int th [TNTH];
    int m_hyst, m_max, m_smax;
    int m_cnt [TNB];
    int m_shist [TNB];

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_th(input int a, input int b, input int c, input int d, input int e);
        th[0] = a; th[1] = b; th[2] = c; th[3] = d; th[4] = e;
        for (int i = 0; i < TNTH; i++) thresholds[i*TDW +: TDW] = TDW'(th[i]);
    endtask

    function automatic int bin_of(input int p);
        int b = 0;
        for (int i = 1; i < TNTH-1; i++) if (p >= th[i]) b++;
        return b;
    endfunction

    // pushes one pixel and checks its result and the held status
    task automatic push(input int p, input bit sol, input bit sof, input bit eof);
        int exp, b, hs;
        in_valid = 1'b1; in_pix = TDW'(p);
        in_sol = sol; in_sof = sof; in_eof = eof;
        hs = sol ? 0 : m_hyst;
        if (p >= th[TNTH-1]) hs = 1;
        else if (p < th[0]) hs = 0;
        m_hyst = hs;
        case (mode)
            2'd1: begin
                exp = th[TNTH-1];
                for (int i = TNTH-1; i >= 0; i--) if (th[i] >= p) exp = th[i];
            end
            2'd2: exp = hs;
            default: exp = (p < th[0]) ? th[0] : ((p > th[TNTH-1]) ? th[TNTH-1] : p);
        endcase
        b = bin_of(p);
        for (int j = 0; j < TNB; j++) begin
            if (sof) m_cnt[j] = 0;
            if (j == b && m_cnt[j] < SAT) m_cnt[j]++;
        end
        m_max = (sof || p > m_max) ? p : m_max;
        if (eof) begin
            m_smax = m_max;
            for (int j = 0; j < TNB; j++) m_shist[j] = m_cnt[j];
        end
        @(negedge clk);
        check("R1 valid", int'(out_valid), 1);
        case (mode)
            2'd1:    check("R3 quantize", int'(out_pix), exp);
            2'd2:    check("R4 hysteresis", int'(out_pix), exp);
            default: check("R2 clip", int'(out_pix), exp);
        endcase
        check("R9 max hold/update", int'(stat_max), m_smax);
    endtask

    task automatic idle();
        in_valid = 1'b0; in_sol = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
        @(negedge clk);
        check("R1 idle", int'(out_valid), 0);
    endtask

    task automatic check_stats();
        check("R8 frame max", int'(stat_max), m_smax);
        for (int j = 0; j < TNB; j++)
            check("R5 R7 bin count", int'(stat_hist[j*TCW +: TCW]), m_shist[j]);
    endtask

    // up sweep then down sweep over every value, two lines per frame
    task automatic sweep_frame();
        for (int v = 0; v < (1 << TDW); v++) push(v, v == 0, v == 0, 1'b0);
        for (int v = (1 << TDW) - 1; v >= 0; v--) push(v, v == (1 << TDW) - 1, 1'b0, v == 0);
        check_stats();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        m_hyst = 0; m_max = 0; m_smax = 0;
        for (int j = 0; j < TNB; j++) begin m_cnt[j] = 0; m_shist[j] = 0; end
        set_th(5, 10, 20, 40, 50);
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 out_valid", int'(out_valid), 0);
        check("R10 out_pix", int'(out_pix), 0);
        check("R10 stat_max", int'(stat_max), 0);
        check("R10 stat_hist", int'(stat_hist), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int s = 0; s < 3; s++) begin
            case (s)
                0: set_th(5, 10, 20, 40, 50);
                1: set_th(0, 16, 32, 48, 63);
                default: set_th(7, 7, 30, 30, 60);
            endcase
            for (int md = 0; md < 4; md++) begin
                mode = 2'(md);
                sweep_frame();
                idle();
            end
        end

        // R6: one-pixel frame right after a saturated frame
        set_th(0, 16, 32, 48, 63);
        mode = 2'd0;
        sweep_frame();
        push(40, 1'b1, 1'b1, 1'b1);
        check("R6 single max", int'(stat_max), 40);
        for (int j = 0; j < TNB; j++)
            check("R6 single bin", int'(stat_hist[j*TCW +: TCW]), (j == 2) ? 1 : 0);

        // R4: line start between bounds while state is 1
        mode = 2'd2;
        set_th(10, 20, 30, 40, 50);
        push(55, 1'b1, 1'b1, 1'b0);
        push(30, 1'b0, 1'b0, 1'b0);
        push(30, 1'b1, 1'b0, 1'b0);
        check("R4 line start clears", int'(out_pix), 0);
        push(5, 1'b0, 1'b0, 1'b0);
        push(30, 1'b0, 1'b0, 1'b1);
        check_stats();

        // R11: thresholds and mode changed between consecutive pixels
        mode = 2'd1;
        push(12, 1'b1, 1'b1, 1'b0);
        check("R11 quant old", int'(out_pix), 20);
        set_th(2, 4, 6, 13, 14);
        push(12, 1'b0, 1'b0, 1'b0);
        check("R11 quant new", int'(out_pix), 13);
        mode = 2'd0;
        push(20, 1'b0, 1'b0, 1'b1);
        check("R11 clip new", int'(out_pix), 14);
        check_stats();
        idle();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule